// File: doc/BRIEF.md
# Scanline-Counting Raster Interrupt Unit

This block raises an interrupt to the CPU when the picture being drawn reaches a chosen scanline. The video side sends a one-cycle pulse at each scanline, with the number of that scanline and a flag that says whether rendering is on. From these inputs the unit tracks whether a rendered frame is in progress. It counts the scanlines since the frame began and compares the count with a target that the CPU writes.

When the count reaches the target, the unit sets a pending flag. If the CPU has enabled the interrupt, the unit drives an active-low request line. The CPU sees two byte-wide registers. One holds the compare target. The other is written to set the enable and read to get the status. Reading the status returns the pending and in-frame flags and clears pending. Games use this to split the screen at a fixed raster position, for example to show a status bar.

Top module: `raster_irq`

## Requirements
- R1: After reset the counter, target, enable, pending and in-frame state are all 0, so `irq_n` is 1 and a status read returns 0x00.
- R2: A CPU write (`cpu_sel` and `cpu_wr`) to address 0x5203 loads the 8-bit compare target.
- R3: A scanline pulse with line number below 241 and rendering on, while not in-frame, sets in-frame, sets the counter to 0 and clears pending.
- R4: A scanline pulse with line number below 241 and rendering on, while in-frame, increments the counter. When the new count equals the target, pending is set.
- R5: A scanline pulse with line number below 241 and rendering off clears in-frame.
- R6: A scanline pulse with line number 241 clears in-frame and sets the counter to 0. It leaves pending unchanged.
- R7: A CPU read (`cpu_sel` and `cpu_rd`) of address 0x5204 returns pending in bit 7, in-frame in bit 6 and 0 in bits 5..0, within the same cycle. The read clears pending.
- R8: `irq_n` is 0 exactly when pending and enable are both 1. A write to 0x5204 with bit 7 set, while pending is already set, drives `irq_n` low on the next cycle.
- R9: A write to 0x5204 with bit 7 clear releases `irq_n` on the next cycle and leaves pending unchanged.
- R10: A target of 0 never sets pending.
- R11: A scanline pulse with line number above 241 changes neither the counter nor the in-frame state.
- R12: When a status read and a target match happen in the same cycle, the read returns the old flags and pending is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Number of the scanline that is signalled |
| render_on | input | 1 | Rendering is active |
| cpu_sel | input | 1 | CPU access select, one cycle |
| cpu_wr | input | 1 | Write enable |
| cpu_rd | input | 1 | Read enable |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data; 0 when no status read is selected |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a status read that lands in the same cycle as a scanline pulse that matches the target. The read must still return the old flags, and the new pending state must not be lost. The bench reaches this case by first placing the frame one line short of the target. It then drives the read and the matching pulse together in one cycle, and follows with a second read. A similar sequence checks that turning on the enable while pending is already set drives the line low at once.

// File: rtl/raster_irq.sv
module raster_irq #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 9,
  parameter int CNT_W = 8,
  parameter int VBLANK_LINE = 241,
  parameter logic [ADDR_W-1:0] TGT_ADDR = 16'h5203,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h5204
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic [LINE_W-1:0] line_num,
  input  logic              render_on,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              irq_n
);
  localparam logic [LINE_W-1:0] VB = LINE_W'(VBLANK_LINE);

  logic [CNT_W-1:0] cnt_q, tgt_q;
  logic en_q, pend_q, frame_q;

  wire wr_tgt = cpu_sel & cpu_wr & (cpu_addr == TGT_ADDR);
  wire wr_ctl = cpu_sel & cpu_wr & (cpu_addr == CTL_ADDR);
  wire rd_ctl = cpu_sel & cpu_rd & (cpu_addr == CTL_ADDR);

  wire visible  = line_num < VB;
  wire at_vb    = line_num == VB;
  wire frame_go = line_stb & visible & render_on & ~frame_q;
  wire step     = line_stb & visible & render_on & frame_q;
  wire stop     = line_stb & ((visible & ~render_on) | at_vb);

  wire [CNT_W-1:0] cnt_nx = cnt_q + 1'b1;
  wire hit = step & (tgt_q != '0) & (cnt_nx == tgt_q);

  logic unused_bits;
  assign unused_bits = ^cpu_wdata[6:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tgt_q   <= '0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      if (frame_go || (line_stb && at_vb)) cnt_q <= '0;
      else if (step)                       cnt_q <= cnt_nx;

      if (frame_go)  frame_q <= 1'b1;
      else if (stop) frame_q <= 1'b0;

      if (hit)           pend_q <= 1'b1;
      else if (frame_go) pend_q <= 1'b0;
      else if (rd_ctl)   pend_q <= 1'b0;

      if (wr_tgt) tgt_q <= cpu_wdata[CNT_W-1:0];
      if (wr_ctl) en_q  <= cpu_wdata[7];
    end
  end

  assign cpu_rdata = rd_ctl ? {pend_q, frame_q, 6'b0} : 8'h00;
  assign irq_n     = ~(pend_q & en_q);
endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 9,
  parameter int CNT_W = 8,
  parameter int VBLANK_LINE = 241,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h5204
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_stb,
  input logic [LINE_W-1:0] line_num,
  input logic              render_on,
  input logic              cpu_sel,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              irq_n,
  input logic              pend_q,
  input logic              frame_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  tgt_q,
  input logic              hit
);
  localparam logic [LINE_W-1:0] VB = LINE_W'(VBLANK_LINE);

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && line_num < VB && render_on && !frame_q) |=> (frame_q && cnt_q == '0 && !pend_q)); // R3
  AST_RENDER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && line_num < VB && !render_on) |=> !frame_q); // R5
  AST_VBLANK_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && line_num == VB) |=> (!frame_q && cnt_q == '0)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_rd && cpu_addr == CTL_ADDR && !hit) |=> !pend_q); // R7
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> pend_q); // R8
  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_wr && cpu_addr == CTL_ADDR && !cpu_wdata[7]) |=> irq_n); // R9
  AST_ZERO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_q == '0 && !pend_q) |=> !pend_q); // R10
  AST_LATE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && line_num > VB) |=> ($stable(cnt_q) && $stable(frame_q))); // R11
endmodule

bind raster_irq raster_irq_chk #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .CNT_W(CNT_W),
  .VBLANK_LINE(VBLANK_LINE), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .line_num(line_num),
  .render_on(render_on), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .irq_n(irq_n),
  .pend_q(pend_q), .frame_q(frame_q), .cnt_q(cnt_q), .tgt_q(tgt_q), .hit(hit)
);

// File: tb/sim_raster_irq.sv
`timescale 1ns/1ps
module sim_raster_irq;
  logic clk = 0, rst_n = 0;
  logic line_stb = 0, render_on = 0;
  logic [8:0] line_num = '0;
  logic cpu_sel = 0, cpu_wr = 0, cpu_rd = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic irq_n;

  always #5 clk = ~clk;

  raster_irq u0 (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .line_num(line_num),
    .render_on(render_on), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_n(irq_n)
  );

  typedef struct { bit is_irq; logic [7:0] exp; string req; } item_t;
  item_t sb[$];
  logic probe = 0;
  int n_run = 0, n_fail = 0;

  always @(negedge clk) begin
    if (probe && sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {7'b0, irq_n} : cpu_rdata;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: %s actual %02h expected %02h", it.req,
                 it.is_irq ? "irq_n" : "status", act, it.exp);
      end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    line_stb = 0; cpu_sel = 0; cpu_wr = 0; cpu_rd = 0; probe = 0;
  endtask

  task automatic strobe(input int ln, input bit ren);
    @(posedge clk); #1;
    line_stb = 1; line_num = 9'(ln); render_on = ren;
    idle();
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    idle();
  endtask

  task automatic read_status(input logic [7:0] exp, input string req, input bit with_stb = 0, input int ln = 0);
    sb.push_back('{0, exp, req});
    @(posedge clk); #1;
    cpu_sel = 1; cpu_rd = 1; cpu_addr = 16'h5204; probe = 1;
    if (with_stb) begin line_stb = 1; line_num = 9'(ln); render_on = 1; end
    idle();
  endtask

  task automatic check_irq(input logic exp, input string req);
    sb.push_back('{1, {7'b0, exp}, req});
    @(posedge clk); #1; probe = 1;
    idle();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    read_status(8'h00, "R1");
    check_irq(1, "R1");

    cpu_write(16'h5203, 8'd3);              // R2 target 3
    cpu_write(16'h5204, 8'h80);
    strobe(0, 1);
    read_status(8'h40, "R3");
    strobe(1, 1); strobe(2, 1);
    check_irq(1, "R4");
    strobe(3, 1);
    check_irq(0, "R8");
    read_status(8'hC0, "R7");
    read_status(8'h40, "R7");
    check_irq(1, "R7");

    strobe(241, 1);
    read_status(8'h00, "R6");
    strobe(0, 1); strobe(1, 1); strobe(2, 1); strobe(3, 1);
    check_irq(0, "R2");
    cpu_write(16'h5204, 8'h00);
    check_irq(1, "R9");
    cpu_write(16'h5204, 8'h80);
    check_irq(0, "R8");
    read_status(8'hC0, "R9");

    strobe(250, 1);
    read_status(8'h40, "R11");
    strobe(4, 1);                          // count continues to 4, no match
    read_status(8'h40, "R11");
    strobe(10, 0);
    read_status(8'h00, "R5");

    cpu_write(16'h5203, 8'd0);
    strobe(0, 1);
    for (int i = 1; i <= 5; i++) strobe(i, 1);
    read_status(8'h40, "R10");
    check_irq(1, "R10");

    cpu_write(16'h5203, 8'd1);
    strobe(241, 1); strobe(0, 1);
    read_status(8'h40, "R12", 1, 1);
    read_status(8'hC0, "R12");

    strobe(241, 1); strobe(0, 1); strobe(1, 1);
    strobe(241, 1);
    check_irq(0, "R6");
    strobe(0, 1);
    read_status(8'h40, "R3");
    check_irq(1, "R3");

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule